// File: doc/BRIEF.md
# Dual-FIFO inter-processor mailbox

This block lets an application processor and an I/O co-processor pass short messages to each other through one shared register set. It holds two independent one-way queues: an outbound queue, which carries messages from the application side to the I/O side, and a return queue, which carries them back. Each message is a 96-bit item made of a 64-bit word and a 32-bit word. Each queue holds 16 messages.

A sender first reads the queue's status register and checks the full flag. It then writes the 64-bit word into a staging register. Writing the 32-bit word commits the whole message to the queue. A receiver first checks the empty flag. It reads the first word, which shows the head of the queue without removing it. It then reads the second word, which removes the head. The second word also returns, above the payload, the live occupancy and pointer values of both queues.

All access goes through a single register port. Reads are combinational and return data in the same cycle. Writes and pops take effect at the next rising clock edge.

Top module: `mbx_top`

## Requirements
- R1: After reset both queues are empty. Their status registers read 0x0000_0000_0002_0000: bit 17 (empty) is 1 and bit 16 (full) is 0.
- R2: A write to a queue's first send register (outbound 0x60, return 0x90) only stages the 64-bit word. The queue's status register stays unchanged.
- R3: A write to the second send register (outbound 0x68, return 0x98) appends the message {staged word, write data bits 31:0} to the queue. Reading the first receive register (outbound 0x70, return 0xA0) returns the head's 64-bit word and does not remove it, so repeated reads return the same value.
- R4: Reading the second receive register (outbound 0x78, return 0xA8) removes the head. Each queue delivers its messages in the order they were committed.
- R5: After 16 commits with no removal, status bit 16 reads 1 and bit 17 reads 0. A commit made while the queue is full is dropped, and the 16 stored messages come out unchanged.
- R6: A read of either receive register while the queue is empty returns zero. Such a read changes nothing: the queue stays empty and its pointers do not move.
- R7: The second receive word returns these fields, each sampled before the removal:
  - bits 31:0: the head's 32-bit word.
  - bits 43:40: the head index of this queue.
  - bits 51:48: this queue's occupancy, saturating at 15.
  - bits 47:44: the write index of the other queue.
  - bits 56:52: the occupancy of the other queue.
  - bits 39:32 and 63:57: zero.
  - Both indices start at 0 and wrap modulo 16.
- R8: The two queues are independent. Traffic on one queue changes neither the contents nor the status register of the other.
- R9: The status registers are at 0x50 (outbound) and 0x80 (return). A read of any send register, or of any address not listed in R2 to R9, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; a read of a second receive register removes the head |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid in the same cycle as bus_rd |

## Verification
The assertions assume that each cycle carries at most one access, that the write and read strobes are never raised together, and that every access lasts exactly one cycle. The stimulus drives every access as a single-cycle strobe set up on the falling edge and never overlaps two accesses. Before it commits to a full queue or reads from an empty one, the stimulus checks the status flags, except in the steps that test the dropped commit and the empty read on purpose.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NCH    = 2;
  localparam int W0_W   = 64;
  localparam int W1_W   = 32;
  localparam int MSG_W  = W0_W + W1_W;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 64;

  localparam logic [ADDR_W-1:0] CTRL_ADDR [NCH] = '{8'h50, 8'h80};
  localparam logic [ADDR_W-1:0] DATA_BASE [NCH] = '{8'h60, 8'h90};

  localparam logic [ADDR_W-1:0] OFF_SEND0 = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_SEND1 = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_RECV0 = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_RECV1 = 8'h18;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_sync = stg_q[1];
endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int W     = 96,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic          push_ok, pop_ok;
  logic [PW-1:0] wr_ptr_n, rd_ptr_n;
  logic [CW-1:0] count_n;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign dout    = mem[rd_ptr];

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    count_n  = count;
    if (push_ok) wr_ptr_n = (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
    if (pop_ok)  rd_ptr_n = (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   count_n = count + 1'b1;
      2'b01:   count_n = count - 1'b1;
      default: count_n = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ($stable(count) && $stable(wr_ptr))); // R5
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> ($stable(rd_ptr) && count == '0)); // R6
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan
  import mbx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_we,
  input  logic              commit,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [MSG_W-1:0]  head,
  output logic [CW-1:0]     count,
  output logic [PW-1:0]     wr_ptr,
  output logic [PW-1:0]     rd_ptr,
  output logic              full,
  output logic              empty
);
  logic [W0_W-1:0] stage_q, stage_n;

  always_comb begin
    stage_n = stage_q;
    if (stage_we) stage_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_n;
  end

  mbx_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (commit),
    .pop    (pop),
    .din    ({stage_q, wdata[W1_W-1:0]}),
    .dout   (head),
    .count  (count),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .full   (full),
    .empty  (empty)
  );

  AST_STAGE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_we && !commit && !pop) |=> $stable(count)); // R2
  AST_COMMIT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !full && !pop) |=> (count == $past(count) + 1'b1)); // R3
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic rst_n_s;
  logic wr_en, rd_en;

  logic [MSG_W-1:0]  head   [NCH];
  logic [CW-1:0]     count  [NCH];
  logic [PW-1:0]     wr_ptr [NCH];
  logic [PW-1:0]     rd_ptr [NCH];
  logic              full   [NCH];
  logic              empty  [NCH];
  logic [DATA_W-1:0] rd_word[NCH];

  mbx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign wr_en = bus_wr;
  assign rd_en = bus_rd & ~bus_wr;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int O = NCH - 1 - i;
    logic hit_ctrl, hit_s0, hit_s1, hit_r0, hit_r1;
    logic [3:0] in_cnt;

    assign hit_ctrl = (bus_addr == CTRL_ADDR[i]);
    assign hit_s0   = (bus_addr == DATA_BASE[i] + OFF_SEND0);
    assign hit_s1   = (bus_addr == DATA_BASE[i] + OFF_SEND1);
    assign hit_r0   = (bus_addr == DATA_BASE[i] + OFF_RECV0);
    assign hit_r1   = (bus_addr == DATA_BASE[i] + OFF_RECV1);
    assign in_cnt   = (count[i] > CW'(15)) ? 4'd15 : 4'(count[i]);

    mbx_chan #(.DEPTH(DEPTH)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .stage_we (wr_en & hit_s0),
      .commit   (wr_en & hit_s1),
      .pop      (rd_en & hit_r1),
      .wdata    (bus_wdata),
      .head     (head[i]),
      .count    (count[i]),
      .wr_ptr   (wr_ptr[i]),
      .rd_ptr   (rd_ptr[i]),
      .full     (full[i]),
      .empty    (empty[i])
    );

    always_comb begin
      rd_word[i] = '0;
      if (rd_en) begin
        if (hit_ctrl)
          rd_word[i] = {46'b0, empty[i], full[i], 16'b0};
        else if (hit_r0 && !empty[i])
          rd_word[i] = head[i][MSG_W-1:W1_W];
        else if (hit_r1 && !empty[i])
          rd_word[i] = {7'b0, 5'(count[O]), in_cnt, 4'(wr_ptr[O]),
                        4'(rd_ptr[i]), 8'b0, head[i][W1_W-1:0]};
      end
    end

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
      (rd_en && (hit_r0 || hit_r1) && empty[i]) |-> (bus_rdata == '0)); // R6
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n_s)
      !(full[i] && empty[i])); // R5
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) bus_rdata = bus_rdata | rd_word[i];
  end

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_en |-> (bus_rdata == '0)); // R9
endmodule

// File: tb/mbx_top_test.sv
module mbx_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;

  int n_vec = 0;
  int n_err = 0;
  logic [95:0] q0[$];
  logic [95:0] q1[$];
  int wr_tot[2];
  int rd_tot[2];

  always #10 clk = ~clk;

  mbx_top uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] ctrl_a(int f); return f == 0 ? 8'h50 : 8'h80; endfunction
  function automatic logic [7:0] base_a(int f); return f == 0 ? 8'h60 : 8'h90; endfunction
  function automatic int qsize(int f); return f == 0 ? q0.size() : q1.size(); endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  // driver: commits a message and records it in the scoreboard when accepted
  task automatic send(input int f, input logic [63:0] w0, input logic [31:0] w1, input bit accept);
    bus_write(base_a(f), w0);
    bus_write(base_a(f) + 8'h08, {32'hDEAD_BEEF, w1});
    if (accept) begin
      if (f == 0) q0.push_back({w0, w1}); else q1.push_back({w0, w1});
      wr_tot[f]++;
    end
  endtask

  // monitor: pops the scoreboard and compares both receive words
  task automatic recv(input int f, input string tag);
    logic [63:0] d;
    logic [95:0] e;
    logic [3:0]  icnt;
    e = (f == 0) ? q0[0] : q1[0];
    icnt = (qsize(f) > 15) ? 4'd15 : 4'(qsize(f));
    bus_read(base_a(f) + 8'h10, d);
    chk({tag, " R3 head word0"}, d, e[95:32]);
    bus_read(base_a(f) + 8'h10, d);
    chk({tag, " R3 word0 re-read no pop"}, d, e[95:32]);
    bus_read(base_a(f) + 8'h18, d);
    chk({tag, " R4 R7 word1 with status"}, d,
        {7'b0, 5'(qsize(1-f)), icnt, 4'(wr_tot[1-f] % 16), 4'(rd_tot[f] % 16), 8'b0, e[31:0]});
    if (f == 0) void'(q0.pop_front()); else void'(q1.pop_front());
    rd_tot[f]++;
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic [63:0] d;
    bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    wr_tot = '{0, 0}; rd_tot = '{0, 0};
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    bus_read(8'h50, d); chk("R1 outbound status after reset", d, 64'h2_0000);
    bus_read(8'h80, d); chk("R1 return status after reset", d, 64'h2_0000);

    bus_write(8'h60, 64'h1111_2222_3333_4444);
    bus_read(8'h50, d); chk("R2 stage only, still empty", d, 64'h2_0000);
    bus_write(8'h68, 64'hFFFF_FFFF_A5A5_0001);
    q0.push_back({64'h1111_2222_3333_4444, 32'hA5A5_0001}); wr_tot[0]++;
    bus_read(8'h50, d); chk("R3 status after commit", d, 64'h0);
    bus_read(8'h80, d); chk("R8 return untouched", d, 64'h2_0000);
    recv(0, "single");
    bus_read(8'h50, d); chk("R4 empty after pop", d, 64'h2_0000);

    send(1, 64'hA0A0_0000_0000_0001, 32'h1001, 1);
    send(0, 64'hB0B0_0000_0000_0001, 32'h2001, 1);
    send(1, 64'hA0A0_0000_0000_0002, 32'h1002, 1);
    send(0, 64'hB0B0_0000_0000_0002, 32'h2002, 1);
    send(1, 64'hA0A0_0000_0000_0003, 32'h1003, 1);
    recv(0, "interleave R8");
    recv(1, "interleave R8");
    recv(1, "interleave R8");
    recv(0, "interleave R8");
    recv(1, "interleave R8");

    for (int k = 0; k < 16; k++)
      send(0, {32'hC0DE_0000, 32'(k)}, 32'h3000 + 32'(k), 1);
    bus_read(8'h50, d); chk("R5 full flag", d, 64'h1_0000);
    send(0, 64'hBAD0_BAD0_BAD0_BAD0, 32'hBAD0_0017, 0);
    bus_read(8'h50, d); chk("R5 still full after drop", d, 64'h1_0000);
    bus_read(8'h80, d); chk("R8 return empty while outbound full", d, 64'h2_0000);
    for (int k = 0; k < 16; k++) recv(0, "drain R5");
    bus_read(8'h50, d); chk("R5 empty after drain, dropped absent", d, 64'h2_0000);

    bus_read(8'h78, d); chk("R6 empty word1 read zero", d, 64'h0);
    bus_read(8'h70, d); chk("R6 empty word0 read zero", d, 64'h0);
    bus_read(8'hA8, d); chk("R6 empty return word1 zero", d, 64'h0);
    bus_read(8'h50, d); chk("R6 still empty", d, 64'h2_0000);

    for (int k = 0; k < 5; k++) send(0, {32'hE000_0000, 32'(k)}, 32'h4000 + 32'(k), 1);
    send(1, 64'hF00D_0000_0000_0000, 32'h5000, 1);
    for (int k = 0; k < 5; k++) recv(0, "wrap R7");
    recv(1, "wrap R7");

    bus_write(8'h90, 64'h7777);
    bus_read(8'h60, d); chk("R9 send reg reads zero", d, 64'h0);
    bus_read(8'h98, d); chk("R9 return send reg reads zero", d, 64'h0);
    bus_read(8'h00, d); chk("R9 unmapped reads zero", d, 64'h0);
    bus_read(8'h80, d); chk("R2 return stage only", d, 64'h2_0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule